// File: doc/BRIEF.md
# Serial Bit Clock and Frame Sync Generator

This block drives the timing of a synchronous audio serial port when the port owns the clocks. A source clock is divided by a programmable ratio to make the bit clock. A frame counter steps once per bit period and drives a frame sync pulse. Both the frame length and the pulse width are set in bit periods, so the same logic gives a one-bit sync or a half-frame channel level. The source is either the module clock or an external clock pin. The external pin passes through a synchronizer and is used on its rising edges.

The divider and the frame logic each have their own run input. The bit clock can therefore run before the frame sync starts, and the frame sync can be restarted on its own without disturbing the bit clock. Configuration is written through a one-word write port. It takes effect only while the divider is stopped. Both outputs have programmable polarity, and the polarity also applies to their idle levels.

Top module: `serial_clk_frame_gen`

## Requirements
- R1: After reset, `bitClk` and `frameSync` are both 0. The divider and frame counters are cleared, and every configuration field reads as zero.
- R2: A write is accepted on a rising clock edge where `cfgWe` is 1 and `genEn` is 0. With `cfgSel`=0 the word holds the divider in bits [7:0], the sync width in bits [15:8] and the frame period in bits [27:16]. With `cfgSel`=1, bit 0 selects the external source, bit 1 inverts the bit clock and bit 2 makes the frame sync active low.
- R3: While running with divider value D, the bit clock has a period of D+1 source ticks. It is at its active level for the first (D+2)/2 ticks of each period, rounded down, and at the other level for the remaining ticks. The first period begins in the cycle after `genEn` is first sampled high. When D=0 the bit clock stays at its active level.
- R4: With the internal source, every module clock cycle is a tick. With the external source, a tick is each rising edge of `extClkIn`, seen after a two-flop synchronizer.
- R5: A frame lasts P+1 bit periods, where P is the frame period field. The frame sync is active for the first W+1 bit periods of each frame, where W is the width field. When W is P or greater, the sync stays active.
- R6: Frame generation starts at the first bit-period boundary reached while both `genEn` and `fsEn` are high. The first frame and its sync begin with the next bit period, with the frame counter at zero.
- R7: With the bit clock inverted, the bit clock and its idle level are complemented. With the sync active low, the frame sync and its inactive level are complemented.
- R8: In the cycle after `genEn` is sampled low, the bit clock is at its idle level and the frame sync is inactive. Both counters are cleared, so the next enable restarts from a fresh bit period and frame.
- R9: In the cycle after `fsEn` is sampled low, the frame sync is inactive. The bit clock continues unchanged.
- R10: A write made while `genEn` is 1 is ignored. The outputs keep the timing and polarity they had before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock; also the internal tick source |
| rstN | input | 1 | Asynchronous active-low reset |
| extClkIn | input | 1 | External source clock pin |
| genEn | input | 1 | Divider run; low stops and clears everything |
| fsEn | input | 1 | Frame sync run; low clears the frame logic |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | 0 selects the timing word, 1 the control word |
| cfgWdata | input | 28 | Configuration write data |
| bitClk | output | 1 | Generated bit clock |
| frameSync | output | 1 | Generated frame sync |

## Verification
If the divider count goes wrong, `bitClk` shows a high or low phase of the wrong length within one bit period. If the frame counter or its start flag is wrong, the sync edges move within one frame of the fault, or the sync starts one bit period early or late. A configuration write that gets through while the divider runs shows up at the next divider wrap. A polarity bit that is dropped flips the idle level in the first cycle after the write. The bench keeps a cycle-level expectation of both outputs and compares them on every cycle of each phase.

// File: rtl/srg_pkg.sv
package srg_pkg;

  // bit positions inside the control word (cfgSel = 1)
  localparam int CTRL_SRC_BIT    = 0;
  localparam int CTRL_CLKINV_BIT = 1;
  localparam int CTRL_FSLOW_BIT  = 2;

  // strobes and levels from control to datapath
  typedef struct packed {
    logic runDiv;   // divider running
    logic tick;     // one source tick this cycle
    logic frameOn;  // frame counter live
    logic clkInv;   // bit clock polarity
    logic fsLow;    // frame sync active low
  } gen_strobe_t;

endpackage

// File: rtl/srg_ctrl.sv
module srg_ctrl
  import srg_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int WID_W       = 8,
  parameter int PER_W       = 12,
  parameter int CFG_W       = DIV_W + WID_W + PER_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extClkIn,
  input  logic              genEn,
  input  logic              fsEn,
  input  logic              cfgWe,
  input  logic              cfgSel,
  input  logic [CFG_W-1:0]  cfgWdata,
  input  logic              bitEnd,
  output gen_strobe_t       strobe,
  output logic [DIV_W-1:0]  divVal,
  output logic [WID_W-1:0]  widVal,
  output logic [PER_W-1:0]  perVal
);

  localparam int WID_LSB = DIV_W;
  localparam int PER_LSB = DIV_W + WID_W;

  logic cfgTake;
  logic srcExtQ, clkInvQ, fsLowQ;
  logic [SYNC_STAGES-1:0] syncQ;
  logic syncPrev;
  logic running;
  logic frameStarted;
  logic extTick;

  assign cfgTake = cfgWe & ~genEn;

  // configuration registers, frozen while the divider runs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divVal  <= '0;
      widVal  <= '0;
      perVal  <= '0;
      srcExtQ <= 1'b0;
      clkInvQ <= 1'b0;
      fsLowQ  <= 1'b0;
    end else if (cfgTake) begin
      if (!cfgSel) begin
        divVal <= cfgWdata[DIV_W-1:0];
        widVal <= cfgWdata[WID_LSB +: WID_W];
        perVal <= cfgWdata[PER_LSB +: PER_W];
      end else begin
        srcExtQ <= cfgWdata[CTRL_SRC_BIT];
        clkInvQ <= cfgWdata[CTRL_CLKINV_BIT];
        fsLowQ  <= cfgWdata[CTRL_FSLOW_BIT];
      end
    end
  end

  // external clock synchronizer chain
  for (genvar gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
    if (gi == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[gi] <= 1'b0;
        else       syncQ[gi] <= extClkIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[gi] <= 1'b0;
        else       syncQ[gi] <= syncQ[gi-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPrev <= 1'b0;
    else       syncPrev <= syncQ[SYNC_STAGES-1];
  end

  assign extTick = syncQ[SYNC_STAGES-1] & ~syncPrev;

  // run state for divider and frame logic
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running      <= 1'b0;
      frameStarted <= 1'b0;
    end else begin
      running <= genEn;
      if (!(genEn && fsEn))
        frameStarted <= 1'b0;
      else if (bitEnd)
        frameStarted <= 1'b1;
    end
  end

  always_comb begin
    strobe.runDiv  = running;
    strobe.tick    = srcExtQ ? extTick : 1'b1;
    strobe.frameOn = frameStarted;
    strobe.clkInv  = clkInvQ;
    strobe.fsLow   = fsLowQ;
  end

endmodule

// File: rtl/srg_datapath.sv
module srg_datapath
  import srg_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int WID_W = 8,
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  gen_strobe_t      strobe,
  input  logic [DIV_W-1:0] divVal,
  input  logic [WID_W-1:0] widVal,
  input  logic [PER_W-1:0] perVal,
  output logic             bitEnd,
  output logic             bitClk,
  output logic             frameSync
);

  localparam int CMP_W = (PER_W > WID_W) ? PER_W : WID_W;

  logic [DIV_W-1:0] divCnt;
  logic [PER_W-1:0] frmCnt;
  logic [DIV_W:0]   hiLen;
  logic             highPhase;
  logic             inPulse;

  assign hiLen     = ({1'b0, divVal} + (DIV_W+1)'(2)) >> 1;
  assign highPhase = {1'b0, divCnt} < hiLen;
  assign bitEnd    = strobe.runDiv & strobe.tick & (divCnt == divVal);
  assign inPulse   = CMP_W'(frmCnt) <= CMP_W'(widVal);

  // divider counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      divCnt <= '0;
    else if (!strobe.runDiv)
      divCnt <= '0;
    else if (strobe.tick)
      divCnt <= (divCnt == divVal) ? '0 : divCnt + 1'b1;
  end

  // frame counter in bit periods
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      frmCnt <= '0;
    else if (!strobe.frameOn)
      frmCnt <= '0;
    else if (bitEnd)
      frmCnt <= (frmCnt == perVal) ? '0 : frmCnt + 1'b1;
  end

  assign bitClk    = (strobe.runDiv & highPhase) ^ strobe.clkInv;
  assign frameSync = (strobe.frameOn & inPulse) ^ strobe.fsLow;

endmodule

// File: rtl/serial_clk_frame_gen.sv
module serial_clk_frame_gen
  import srg_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int WID_W       = 8,
  parameter int PER_W       = 12,
  parameter int SYNC_STAGES = 2,
  localparam int CFG_W      = DIV_W + WID_W + PER_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extClkIn,
  input  logic             genEn,
  input  logic             fsEn,
  input  logic             cfgWe,
  input  logic             cfgSel,
  input  logic [CFG_W-1:0] cfgWdata,
  output logic             bitClk,
  output logic             frameSync
);

  gen_strobe_t      strobe;
  logic             bitEnd;
  logic [DIV_W-1:0] divVal;
  logic [WID_W-1:0] widVal;
  logic [PER_W-1:0] perVal;

  srg_ctrl #(
    .DIV_W(DIV_W), .WID_W(WID_W), .PER_W(PER_W),
    .CFG_W(CFG_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .extClkIn(extClkIn),
    .genEn(genEn), .fsEn(fsEn),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .bitEnd(bitEnd), .strobe(strobe),
    .divVal(divVal), .widVal(widVal), .perVal(perVal)
  );

  srg_datapath #(
    .DIV_W(DIV_W), .WID_W(WID_W), .PER_W(PER_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .divVal(divVal), .widVal(widVal), .perVal(perVal),
    .bitEnd(bitEnd), .bitClk(bitClk), .frameSync(frameSync)
  );

endmodule

// File: rtl/srg_checker.sv
module srg_checker
  import srg_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int WID_W = 8,
  parameter int PER_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             genEn,
  input logic             fsEn,
  input logic             bitClk,
  input logic             frameSync,
  input logic             bitEnd,
  input gen_strobe_t      strobe,
  input logic [DIV_W-1:0] divVal,
  input logic [WID_W-1:0] widVal,
  input logic [PER_W-1:0] perVal
);

  // R8: divider stop forces the bit clock idle
  a_r8_clock_idle: assert property (@(posedge clk) disable iff (!rstN)
    !genEn |=> (bitClk == strobe.clkInv));

  // R9: frame run low forces the sync inactive
  a_r9_sync_off: assert property (@(posedge clk) disable iff (!rstN)
    !fsEn |=> (frameSync == strobe.fsLow));

  // R10: configuration is frozen while the divider runs
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    genEn |=> ($stable(divVal) && $stable(widVal) && $stable(perVal)
               && $stable(strobe.clkInv) && $stable(strobe.fsLow)));

  // R6: frame logic only starts on a bit-period boundary
  a_r6_start_on_boundary: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.frameOn) |-> $past(bitEnd));

  // R5: an active sync needs a running divider
  a_r5_sync_needs_clock: assert property (@(posedge clk) disable iff (!rstN)
    (frameSync != strobe.fsLow) |-> strobe.runDiv);

endmodule

bind serial_clk_frame_gen srg_checker #(
  .DIV_W(DIV_W), .WID_W(WID_W), .PER_W(PER_W)
) u_chk (
  .clk(clk), .rstN(rstN), .genEn(genEn), .fsEn(fsEn),
  .bitClk(bitClk), .frameSync(frameSync), .bitEnd(bitEnd),
  .strobe(strobe), .divVal(divVal), .widVal(widVal), .perVal(perVal)
);

// File: tb/sim_serial_clk_frame_gen.sv
`timescale 1ns/100ps
module sim_serial_clk_frame_gen;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extClkIn = 1'b0;
  logic genEn = 1'b0;
  logic fsEn = 1'b0;
  logic cfgWe = 1'b0;
  logic cfgSel = 1'b0;
  logic [27:0] cfgWdata = '0;
  logic bitClk, frameSync;

  int total = 0;
  int bad = 0;
  int cycle = 0;
  bit finished = 0;
  bit extOn = 0;
  int extHalf = 3;

  always #2.5 clk = ~clk;

  serial_clk_frame_gen u0 (
    .clk(clk), .rstN(rstN), .extClkIn(extClkIn), .genEn(genEn), .fsEn(fsEn),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .bitClk(bitClk), .frameSync(frameSync)
  );

  // expectation model built from the requirements
  logic [7:0]  mDiv, mWid;
  logic [11:0] mPer;
  logic mExt, mInv, mFsLow;
  logic mS0, mS1, mPrev;
  logic mRun, mStarted;
  int   mDivCnt, mFrm;
  logic mTick, mBitEnd, expBit, expFs;

  assign mTick   = mExt ? (mS1 & ~mPrev) : 1'b1;
  assign mBitEnd = mRun && mTick && (mDivCnt == int'(mDiv));
  assign expBit  = (mRun && (mDivCnt < (int'(mDiv) + 2) / 2)) ^ mInv;
  assign expFs   = (mStarted && (mFrm <= int'(mWid))) ^ mFsLow;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mDiv <= '0; mWid <= '0; mPer <= '0;
      mExt <= 0; mInv <= 0; mFsLow <= 0;
      mS0 <= 0; mS1 <= 0; mPrev <= 0;
      mRun <= 0; mStarted <= 0; mDivCnt <= 0; mFrm <= 0;
    end else begin
      if (cfgWe && !genEn) begin
        if (!cfgSel) begin
          mDiv <= cfgWdata[7:0]; mWid <= cfgWdata[15:8]; mPer <= cfgWdata[27:16];
        end else begin
          mExt <= cfgWdata[0]; mInv <= cfgWdata[1]; mFsLow <= cfgWdata[2];
        end
      end
      mS0 <= extClkIn; mS1 <= mS0; mPrev <= mS1;
      mRun <= genEn;
      if (!mRun) mDivCnt <= 0;
      else if (mTick) mDivCnt <= (mDivCnt == int'(mDiv)) ? 0 : mDivCnt + 1;
      if (!(fsEn && genEn)) mStarted <= 0;
      else if (mBitEnd) mStarted <= 1;
      if (!mStarted) mFrm <= 0;
      else if (mBitEnd) mFrm <= (mFrm == int'(mPer)) ? 0 : mFrm + 1;
    end
  end

  always @(posedge clk) cycle <= cycle + 1;

  // external clock pin driver
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (extOn) begin
        cnt++;
        if (cnt >= extHalf) begin
          cnt = 0;
          extClkIn = ~extClkIn;
        end
      end
    end
  end

  function automatic logic [27:0] timingWord(int d, int w, int p);
    return {p[11:0], w[7:0], d[7:0]};
  endfunction

  function automatic logic [27:0] ctrlWord(bit ext, bit inv, bit fsl);
    return {25'd0, fsl, inv, ext};
  endfunction

  task automatic writeCfg(bit sel, logic [27:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgWdata = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic runPhase(int n, string tag);
    int mism = 0;
    int firstCyc = 0;
    logic gb = 0, gf = 0, eb = 0, ef = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (bitClk !== expBit || frameSync !== expFs) begin
        if (mism == 0) begin
          firstCyc = cycle; gb = bitClk; gf = frameSync; eb = expBit; ef = expFs;
        end
        mism++;
      end
    end
    total++;
    if (mism != 0) begin
      bad++;
      $display("FAIL %s: cycle %0d bitClk=%b exp=%b frameSync=%b exp=%b (%0d bad cycles)",
               tag, firstCyc, gb, eb, gf, ef, mism);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(150000 * 5);
    bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (bitClk !== 1'b0 || frameSync !== 1'b0) begin
      bad++;
      $display("FAIL R1: bitClk=%b frameSync=%b expected 0 0", bitClk, frameSync);
    end
    rstN = 1'b1;
    runPhase(5, "R1 idle after reset");

    // R2 R3 R5 R6: basic timing
    writeCfg(0, timingWord(3, 0, 7));
    @(negedge clk); genEn = 1; fsEn = 1;
    runPhase(120, "R2 R3 R5 R6 basic frame");

    // R10: writes while running are dropped
    writeCfg(0, timingWord(1, 2, 2));
    writeCfg(1, ctrlWord(0, 1, 1));
    runPhase(80, "R10 write while running");

    // R9 then R6 restart of frame logic only
    @(negedge clk); fsEn = 0;
    runPhase(17, "R9 frame run low");
    @(negedge clk); fsEn = 1;
    runPhase(90, "R6 frame restart on boundary");

    // R8 stop and restart
    @(negedge clk); genEn = 0;
    runPhase(10, "R8 stop idle");
    @(negedge clk); genEn = 1;
    runPhase(70, "R8 restart from zero");

    // R3 R5: divider zero and width beyond period
    @(negedge clk); genEn = 0; fsEn = 0;
    writeCfg(0, timingWord(0, 5, 3));
    @(negedge clk); genEn = 1; fsEn = 1;
    runPhase(40, "R3 R5 div zero wide sync");

    // R7 polarity, idle levels first
    @(negedge clk); genEn = 0; fsEn = 0;
    writeCfg(0, timingWord(4, 1, 5));
    writeCfg(1, ctrlWord(0, 1, 1));
    runPhase(8, "R7 inverted idle levels");
    @(negedge clk); genEn = 1; fsEn = 1;
    runPhase(120, "R7 inverted running");

    // R4 external source
    @(negedge clk); genEn = 0; fsEn = 0;
    extOn = 1;
    writeCfg(0, timingWord(2, 1, 3));
    writeCfg(1, ctrlWord(1, 0, 0));
    @(negedge clk); genEn = 1; fsEn = 1;
    runPhase(320, "R4 external source");

    // random configurations
    for (int k = 0; k < 8; k++) begin
      int d = $urandom_range(0, 6);
      int w = $urandom_range(0, 15);
      int p = $urandom_range(0, 15);
      bit ex = ($urandom_range(0, 3) == 0);
      bit iv = $urandom_range(0, 1);
      bit fl = $urandom_range(0, 1);
      @(negedge clk); genEn = 0; fsEn = 0;
      extHalf = $urandom_range(1, 4);
      writeCfg(0, timingWord(d, w, p));
      writeCfg(1, ctrlWord(ex, iv, fl));
      @(negedge clk); genEn = 1; fsEn = 1;
      runPhase(150, "R3 R4 R5 R7 random config");
      @(negedge clk); fsEn = 0;
      runPhase(int'($urandom_range(2, 12)), "R9 random frame stop");
      @(negedge clk); fsEn = 1;
      runPhase(150, "R6 R10 random frame restart");
    end

    summary();
  end

endmodule